// File: doc/BRIEF.md
# Sixteen-Bit Address Adder with Flag Update

This unit performs the two wide additions used by a small eight-bit processor: adding a sixteen-bit register pair into the HL pair, and adding a signed eight-bit displacement to the stack pointer. The sum is formed combinationally and appears on the result output in the same cycle the operands are presented. The caller decides where the result is written, either SP or HL.

The four condition flags (zero, subtract, half-carry, carry) are held in a register inside the unit. On a clock edge with the strobe high, the flags are updated according to the selected operation. Each add form sets the flags by its own rule. With the strobe low, or with the idle code selected, the flags keep their value.

Top module: `addr_adder16`

## Requirements
- R1: The `op_sel` encoding is 2'b00 = register-pair add (`sum = opa + opb` mod 2^16), 2'b01 = displacement add with the result meant for SP, 2'b10 = displacement add with the result meant for HL, and 2'b11 = idle. For codes 01 and 10, `sum = opa + sign_extend(opb[7:0])` mod 2^16. For code 11, `sum` is 0.
- R2: After a strobed register-pair add, H equals bit 12 of `(opa & 0xFFF) + (opb & 0xFFF)`.
- R3: After a strobed register-pair add, C equals bit 16 of the 17-bit sum `opa + opb`.
- R4: A strobed register-pair add clears N and leaves Z at its previous value.
- R5: After a strobed displacement add (codes 01 and 10), H is the carry out of bit 3 and C is the carry out of bit 7 of the unsigned add `opa[7:0] + opb[7:0]`, with no carry-in.
- R6: A strobed displacement add clears Z and N, whichever of the two codes is used.
- R7: With `strobe` low, or with `op_sel` = 2'b11, all four flags keep their value across the edge.
- R8: A synchronous reset clears all four flags. The flag outputs are `flag_z`, `flag_n`, `flag_h` and `flag_c`.
- R9: `sum` is combinational and depends only on `opa`, `opb` and `op_sel`. The flags change only at the clock edge that follows a strobed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Update the flags at this edge |
| op_sel | input | 2 | Operation select |
| opa | input | 16 | HL value (code 00) or SP value (codes 01, 10) |
| opb | input | 16 | Register pair (code 00); the displacement is in bits 7:0 |
| sum | output | 16 | Combinational result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Subtract flag |
| flag_h | output | 1 | Half-carry flag |
| flag_c | output | 1 | Carry flag |

## Verification
The embedded assertions check these rules on every cycle:
- Z is preserved across a register-pair add.
- Z and N are clear after a displacement add.
- Flags are held when the strobe is low or the idle code is selected.
- Flags are clear after reset.
- The register-pair carry matches the wrapped sum.

The exact half-carry and carry values are checked only by the bench. It compares them against independently computed reference functions over random operands and directed carry-boundary values, such as 0x0FFF+0x0001, 0xFFFF+0x0001, a displacement of -1, and a low byte of 0x0F. The bench also confirms that the two displacement codes give identical results.

// File: rtl/addr_adder16.sv
module addr_adder16 #(
  parameter int W  = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [1:0]    op_sel,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  output logic [W-1:0]  sum,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_h,
  output logic          flag_c
);
  localparam int HB = W - 4;
  localparam int NB = DW / 2;

  logic          is_pair, is_disp;
  logic [W:0]    pair_full;
  logic [HB:0]   pair_low;
  logic [W-1:0]  disp_ext;
  logic [DW:0]   byte_full;
  logic [NB:0]   nib_full;

  assign is_pair   = (op_sel == 2'b00);
  assign is_disp   = (op_sel == 2'b01) || (op_sel == 2'b10);
  assign pair_full = {1'b0, opa} + {1'b0, opb};
  assign pair_low  = {1'b0, opa[HB-1:0]} + {1'b0, opb[HB-1:0]};
  assign disp_ext  = {{(W-DW){opb[DW-1]}}, opb[DW-1:0]};
  assign byte_full = {1'b0, opa[DW-1:0]} + {1'b0, opb[DW-1:0]};
  assign nib_full  = {1'b0, opa[NB-1:0]} + {1'b0, opb[NB-1:0]};

  assign sum = is_pair ? pair_full[W-1:0] :
               is_disp ? (opa + disp_ext) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_h <= 1'b0;
      flag_c <= 1'b0;
    end else if (strobe && is_pair) begin
      flag_n <= 1'b0;
      flag_h <= pair_low[HB];
      flag_c <= pair_full[W];
    end else if (strobe && is_disp) begin
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_h <= nib_full[NB];
      flag_c <= byte_full[DW];
    end
  end

  a_r4_z_kept: assert property (@(posedge clk) disable iff (rst)
    (strobe && op_sel == 2'b00) |=> (flag_z == $past(flag_z) && !flag_n));
  a_r6_disp_clears: assert property (@(posedge clk) disable iff (rst)
    (strobe && (op_sel == 2'b01 || op_sel == 2'b10)) |=> (!flag_z && !flag_n));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe || op_sel == 2'b11) |=>
      ($stable(flag_z) && $stable(flag_n) && $stable(flag_h) && $stable(flag_c)));
  a_r8_reset: assert property (@(posedge clk)
    rst |=> !(flag_z || flag_n || flag_h || flag_c));
  a_r3_carry_wrap: assert property (@(posedge clk) disable iff (rst)
    (strobe && op_sel == 2'b00) |=> (flag_c == ($past(sum) < $past(opa))));
endmodule

// File: tb/tb_addr_adder16.sv
module tb_addr_adder16;
  logic clk = 0, rst, strobe;
  logic [1:0] op_sel;
  logic [15:0] opa, opb, sum;
  logic flag_z, flag_n, flag_h, flag_c;
  int nchk = 0, nerr = 0;
  logic ez, en, eh, ec;

  always #10 clk = ~clk;

  addr_adder16 dut (.clk(clk), .rst(rst), .strobe(strobe), .op_sel(op_sel),
    .opa(opa), .opb(opb), .sum(sum), .flag_z(flag_z), .flag_n(flag_n),
    .flag_h(flag_h), .flag_c(flag_c));

  function automatic logic [15:0] ref_sum(input logic [1:0] s, input logic [15:0] a, b);
    logic [15:0] d;
    d = {{8{b[7]}}, b[7:0]};
    if (s == 2'b00) return a + b;
    if (s == 2'b11) return 16'h0;
    return a + d;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] s, input logic st, input logic [15:0] a, b);
    int full, lo;
    @(negedge clk);
    op_sel = s; strobe = st; opa = a; opb = b;
    #1 chk("R1 sum", sum, ref_sum(s, a, b));
    if (st && s == 2'b00) begin
      full = int'(a) + int'(b);
      lo = int'(a[11:0]) + int'(b[11:0]);
      en = 0; eh = lo[12]; ec = full[16];
    end else if (st && s != 2'b11) begin
      full = int'(a[7:0]) + int'(b[7:0]);
      lo = int'(a[3:0]) + int'(b[3:0]);
      ez = 0; en = 0; eh = lo[4]; ec = full[8];
    end
    @(negedge clk);
    strobe = 0;
    chk("R2 H", {15'b0, flag_h}, {15'b0, eh});
    chk("R3 C", {15'b0, flag_c}, {15'b0, ec});
    chk("R4 R6 N", {15'b0, flag_n}, {15'b0, en});
    chk("R4 R6 R7 Z", {15'b0, flag_z}, {15'b0, ez});
  endtask

  initial begin
    #1_000_000;
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; strobe = 0; op_sel = 2'b11; opa = 0; opb = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    ez = 0; en = 0; eh = 0; ec = 0;
    chk("R8 reset", {12'b0, flag_z, flag_n, flag_h, flag_c}, 16'h0);
    // R2 R3 corners
    apply(2'b00, 1, 16'h0FFF, 16'h0001);
    apply(2'b00, 1, 16'hFFFF, 16'h0001);
    apply(2'b00, 1, 16'h8000, 16'h8000);
    // R5 R6 corners, both destinations
    apply(2'b01, 1, 16'h000F, 16'h0001);
    apply(2'b10, 1, 16'h00FF, 16'h00FF);
    apply(2'b01, 1, 16'h1000, 16'h0080);
    // R7 hold: strobe low and idle code
    apply(2'b00, 0, 16'hFFFF, 16'hFFFF);
    apply(2'b11, 1, 16'hFFFF, 16'hFFFF);
    // R9 / random
    for (int i = 0; i < 400; i++)
      apply(2'($urandom), 1'($urandom), 16'($urandom), 16'($urandom));
    // R8 reset after activity
    apply(2'b00, 1, 16'hFFFF, 16'h0FFF);
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk("R8 reset again", {12'b0, flag_z, flag_n, flag_h, flag_c}, 16'h0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule